// File: doc/BRIEF.md
# Two-Pipe Priority Layer Compositor

The compositor merges four graphics layers into one RGB pixel per beat. Every beat carries, for each layer, an ARGB pixel at the current screen position and a flag saying whether that layer covers the position. Each layer is configured with an enable, a pipe choice (back pipe 0 or front pipe 1), a priority, a global alpha byte and a global alpha enable. In the first stage each pipe keeps only its highest-priority covering layer. In the second stage the front pipe is alpha-blended over the back pipe, and the back pipe itself falls back to a background colour when nothing covers it.

Layer attributes are taken from the configuration pins on a beat that starts a frame and are held for the rest of that frame. This lets software change the pins at any time without tearing a frame. An optional workaround mode copies a hardware limitation: an alpha-bearing layer at the bottom slot of the back pipe is replaced by the background colour.

Pixels enter and leave on valid/ready streams. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. `out_px` is held stable while `out_valid` is high and `out_ready` is low. The whole pipeline freezes during that stall, so `in_ready` is low exactly when the output holds a beat that is not being taken.

Top module: `layer_compositor`

## Requirements
- R1: Within each pipe, the winning layer is the one with the largest priority among the layers that are enabled, flagged as covering, and assigned to that pipe (pipe bit 0 = back, 1 = front). Layer i uses pixel bits [32i+31:32i] (A in 31:24, R 23:16, G 15:8, B 7:0) and priority bits [2i+1:2i].
- R2: When two candidates on one pipe share the top priority, the lower layer index wins.
- R3: When no layer qualifies for the back pipe, the back-pipe colour is `cfg_bg` (R in 23:16, G 15:8, B 7:0).
- R4: When no layer qualifies for the front pipe, `out_px` equals the back-pipe colour exactly.
- R5: A front-pipe winner has pixel alpha A when its `in_has_alpha` bit is set, and 255 otherwise. Each output channel is (a·F + (255−a)·B + 127)/255, truncated, where F is the front colour and B the back colour.
- R6: When a layer's global alpha enable is set, its alpha becomes (a·g + 127)/255, where g is its byte of `cfg_galpha` (bits [8i+7:8i]).
- R7: With `cfg_quirk` high, a back-pipe winner of priority 0 that carries alpha (its `in_has_alpha` bit is set, or global alpha is enabled with g ≠ 255) is shown as `cfg_bg`.
- R8: The enable, pipe, priority and global alpha settings of an accepted beat with `in_sof` high come from the pins and are stored. Later beats without `in_sof` use the stored copy and ignore pin changes.
- R9: With `out_ready` high, a beat accepted at edge k makes `out_valid` high after edge k+1, and not after edge k.
- R10: While `out_valid` is high and `out_ready` is low, `out_px` and `out_valid` hold and `in_ready` is low. Otherwise `in_ready` is high.
- R11: Reset clears `out_valid` and all stored layer settings, so a beat without `in_sof` before any frame start shows `cfg_bg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Compositor can take a beat |
| in_sof | input | 1 | Beat starts a frame; load layer settings |
| in_px_valid | input | 4 | Per-layer coverage flag |
| in_px | input | 128 | Per-layer ARGB pixels |
| in_has_alpha | input | 4 | Per-layer pixel format carries alpha |
| cfg_layer_en | input | 4 | Per-layer enable |
| cfg_pipe | input | 4 | Per-layer pipe select |
| cfg_prio | input | 8 | Per-layer 2-bit priority |
| cfg_galpha | input | 32 | Per-layer global alpha byte |
| cfg_galpha_en | input | 4 | Per-layer global alpha enable |
| cfg_bg | input | 24 | Background RGB |
| cfg_quirk | input | 1 | Bottom-slot alpha workaround mode |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_px | output | 24 | Composited RGB |

## Verification
The assertions assume that every input has a known value once reset is released. The priority and tie checks compare candidate sets in the same cycle. The blend checks compare `out_px` with the stage-one colours one edge earlier, so they rely on the configuration seen at acceptance. The bench keeps to these assumptions: it sets every pin before it releases reset and changes inputs only at falling edges. It drives `in_valid` only through a task that also fixes all pixel and configuration pins for that beat.

// File: rtl/comp_pkg.sv
package comp_pkg;
  typedef enum logic {
    PIPE_BACK  = 1'b0,
    PIPE_FRONT = 1'b1
  } pipe_e;
endpackage

// File: rtl/comp_attr_shadow.sv
module comp_attr_shadow #(
  parameter int LAYERS = 4,
  parameter int PRIO_W = 2,
  parameter int CH_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic                     use_live,
  input  logic [LAYERS-1:0]        live_en,
  input  logic [LAYERS-1:0]        live_pipe,
  input  logic [LAYERS*PRIO_W-1:0] live_prio,
  input  logic [LAYERS*CH_W-1:0]   live_ga,
  input  logic [LAYERS-1:0]        live_ga_en,
  output logic [LAYERS-1:0]        eff_en,
  output logic [LAYERS-1:0]        eff_pipe,
  output logic [LAYERS*PRIO_W-1:0] eff_prio,
  output logic [LAYERS*CH_W-1:0]   eff_ga,
  output logic [LAYERS-1:0]        eff_ga_en
);
  logic [LAYERS-1:0]        sh_en;
  logic [LAYERS-1:0]        sh_pipe;
  logic [LAYERS*PRIO_W-1:0] sh_prio;
  logic [LAYERS*CH_W-1:0]   sh_ga;
  logic [LAYERS-1:0]        sh_ga_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_en    <= '0;
      sh_pipe  <= '0;
      sh_prio  <= '0;
      sh_ga    <= '0;
      sh_ga_en <= '0;
    end else if (capture) begin
      sh_en    <= live_en;
      sh_pipe  <= live_pipe;
      sh_prio  <= live_prio;
      sh_ga    <= live_ga;
      sh_ga_en <= live_ga_en;
    end
  end

  always_comb begin
    if (use_live) begin
      eff_en    = live_en;
      eff_pipe  = live_pipe;
      eff_prio  = live_prio;
      eff_ga    = live_ga;
      eff_ga_en = live_ga_en;
    end else begin
      eff_en    = sh_en;
      eff_pipe  = sh_pipe;
      eff_prio  = sh_prio;
      eff_ga    = sh_ga;
      eff_ga_en = sh_ga_en;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(sh_en) && $stable(sh_prio) && $stable(sh_pipe)); // R8
endmodule

// File: rtl/comp_pipe_select.sv
module comp_pipe_select
  import comp_pkg::*;
#(
  parameter int    LAYERS  = 4,
  parameter int    PRIO_W  = 2,
  parameter int    CH_W    = 8,
  parameter pipe_e PIPE_ID = PIPE_BACK
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LAYERS-1:0]          en,
  input  logic [LAYERS-1:0]          pipe,
  input  logic [LAYERS-1:0]          px_valid,
  input  logic [LAYERS-1:0]          has_alpha,
  input  logic [LAYERS-1:0]          ga_en,
  input  logic [LAYERS*PRIO_W-1:0]   prio,
  input  logic [LAYERS*CH_W-1:0]     ga,
  input  logic [LAYERS*4*CH_W-1:0]   px,
  output logic                       hit,
  output logic [3*CH_W-1:0]          win_rgb,
  output logic [CH_W-1:0]            win_alpha,
  output logic [PRIO_W-1:0]          win_prio,
  output logic                       win_carry
);
  localparam int PX_W  = 4 * CH_W;
  localparam int IDX_W = (LAYERS > 1) ? $clog2(LAYERS) : 1;
  localparam int MW    = 2 * CH_W + 1;
  localparam logic [CH_W-1:0] AMAX = '1;

  logic [PRIO_W-1:0] prio_a  [LAYERS];
  logic [PX_W-1:0]   px_a    [LAYERS];
  logic [CH_W-1:0]   alpha_a [LAYERS];
  logic              carry_a [LAYERS];
  logic [LAYERS-1:0] cand;
  logic [IDX_W-1:0]  idx;

  for (genvar i = 0; i < LAYERS; i++) begin : g_layer
    logic [CH_W-1:0] raw_a;
    logic [CH_W-1:0] ga_i;
    logic [MW-1:0]   scaled;
    assign prio_a[i] = prio[i*PRIO_W +: PRIO_W];
    assign px_a[i]   = px[i*PX_W +: PX_W];
    assign ga_i      = ga[i*CH_W +: CH_W];
    assign cand[i]   = en[i] && px_valid[i] && (pipe[i] == logic'(PIPE_ID));
    assign raw_a     = has_alpha[i] ? px_a[i][PX_W-1 -: CH_W] : AMAX;
    assign scaled    = (MW'(raw_a) * MW'(ga_i) + MW'(AMAX >> 1)) / MW'(AMAX);
    assign alpha_a[i] = ga_en[i] ? scaled[CH_W-1:0] : raw_a;
    assign carry_a[i] = has_alpha[i] || (ga_en[i] && (ga_i != AMAX));
  end

  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    win_prio = '0;
    for (int i = 0; i < LAYERS; i++) begin
      if (cand[i] && (!hit || (prio_a[i] > win_prio))) begin
        hit      = 1'b1;
        idx      = IDX_W'(i);
        win_prio = prio_a[i];
      end
    end
  end

  assign win_rgb   = px_a[idx][3*CH_W-1:0];
  assign win_alpha = alpha_a[idx];
  assign win_carry = carry_a[idx];

  for (genvar i = 0; i < LAYERS; i++) begin : g_chk
    AST_WIN_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      cand[i] |-> hit && (prio_a[i] <= win_prio)); // R1
    AST_TIE_LOW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (cand[i] && (prio_a[i] == win_prio)) |-> (idx <= IDX_W'(i))); // R2
  end
endmodule

// File: rtl/comp_blend_lane.sv
module comp_blend_lane #(
  parameter int CH_W = 8
) (
  input  logic [CH_W-1:0] alpha,
  input  logic [CH_W-1:0] front,
  input  logic [CH_W-1:0] back,
  output logic [CH_W-1:0] mixed
);
  localparam int ACC_W = 2 * CH_W + 2;
  localparam logic [CH_W-1:0] AMAX = '1;

  logic [CH_W-1:0]  inv_a;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] quo;

  assign inv_a = AMAX - alpha;
  assign acc   = ACC_W'(alpha) * ACC_W'(front) + ACC_W'(inv_a) * ACC_W'(back)
               + ACC_W'(AMAX >> 1);
  assign quo   = acc / ACC_W'(AMAX);
  assign mixed = quo[CH_W-1:0];
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import comp_pkg::*;
#(
  parameter int LAYERS = 4,
  parameter int PRIO_W = 2,
  parameter int CH_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_sof,
  input  logic [LAYERS-1:0]        in_px_valid,
  input  logic [LAYERS*4*CH_W-1:0] in_px,
  input  logic [LAYERS-1:0]        in_has_alpha,
  input  logic [LAYERS-1:0]        cfg_layer_en,
  input  logic [LAYERS-1:0]        cfg_pipe,
  input  logic [LAYERS*PRIO_W-1:0] cfg_prio,
  input  logic [LAYERS*CH_W-1:0]   cfg_galpha,
  input  logic [LAYERS-1:0]        cfg_galpha_en,
  input  logic [3*CH_W-1:0]        cfg_bg,
  input  logic                     cfg_quirk,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [3*CH_W-1:0]        out_px
);
  localparam int RGB_W = 3 * CH_W;
  localparam int NPIPE = 2;
  localparam logic [CH_W-1:0] AMAX = '1;

  logic advance;
  logic accept;

  logic [LAYERS-1:0]        a_en;
  logic [LAYERS-1:0]        a_pipe;
  logic [LAYERS*PRIO_W-1:0] a_prio;
  logic [LAYERS*CH_W-1:0]   a_ga;
  logic [LAYERS-1:0]        a_ga_en;

  logic              hit_v   [NPIPE];
  logic [RGB_W-1:0]  rgb_v   [NPIPE];
  logic [CH_W-1:0]   alpha_v [NPIPE];
  logic [PRIO_W-1:0] prio_v  [NPIPE];
  logic              carry_v [NPIPE];

  logic             quirk_hide;
  logic [RGB_W-1:0] back_rgb;

  logic             s1_valid;
  logic [RGB_W-1:0] s1_back;
  logic [RGB_W-1:0] s1_front;
  logic             s1_front_hit;
  logic [CH_W-1:0]  s1_alpha;
  logic [CH_W-1:0]  use_alpha;
  logic [RGB_W-1:0] mix_rgb;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;

  comp_attr_shadow #(.LAYERS(LAYERS), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (accept && in_sof),
    .use_live   (in_sof),
    .live_en    (cfg_layer_en),
    .live_pipe  (cfg_pipe),
    .live_prio  (cfg_prio),
    .live_ga    (cfg_galpha),
    .live_ga_en (cfg_galpha_en),
    .eff_en     (a_en),
    .eff_pipe   (a_pipe),
    .eff_prio   (a_prio),
    .eff_ga     (a_ga),
    .eff_ga_en  (a_ga_en)
  );

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    comp_pipe_select #(
      .LAYERS (LAYERS),
      .PRIO_W (PRIO_W),
      .CH_W   (CH_W),
      .PIPE_ID(pipe_e'(p))
    ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (a_en),
      .pipe      (a_pipe),
      .px_valid  (in_px_valid),
      .has_alpha (in_has_alpha),
      .ga_en     (a_ga_en),
      .prio      (a_prio),
      .ga        (a_ga),
      .px        (in_px),
      .hit       (hit_v[p]),
      .win_rgb   (rgb_v[p]),
      .win_alpha (alpha_v[p]),
      .win_prio  (prio_v[p]),
      .win_carry (carry_v[p])
    );
  end

  assign quirk_hide = cfg_quirk && hit_v[0] && (prio_v[0] == '0) && carry_v[0];
  assign back_rgb   = (!hit_v[0] || quirk_hide) ? cfg_bg : rgb_v[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else if (advance) begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      s1_back      <= back_rgb;
      s1_front     <= rgb_v[1];
      s1_front_hit <= hit_v[1];
      s1_alpha     <= alpha_v[1];
      out_px       <= mix_rgb;
    end
  end

  assign use_alpha = s1_front_hit ? s1_alpha : '0;

  for (genvar c = 0; c < 3; c++) begin : g_lane
    comp_blend_lane #(.CH_W(CH_W)) u_lane (
      .alpha (use_alpha),
      .front (s1_front[c*CH_W +: CH_W]),
      .back  (s1_back[c*CH_W +: CH_W]),
      .mixed (mix_rgb[c*CH_W +: CH_W])
    );
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_px)); // R10
  AST_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && out_ready) |=> s1_valid ##1 out_valid); // R9
  AST_FRONT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_front_hit && advance) |=> out_px == $past(s1_back)); // R4
  AST_FRONT_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_front_hit && (s1_alpha == AMAX) && advance)
      |=> out_px == $past(s1_front)); // R5
  AST_BG_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit_v[0]) |=> s1_back == $past(cfg_bg)); // R3
  AST_QUIRK_BG: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_quirk && hit_v[0] && (prio_v[0] == '0) && carry_v[0])
      |=> s1_back == $past(cfg_bg)); // R7
endmodule

// File: tb/layer_compositor_tb_top.sv
`timescale 1ns/1ps
module layer_compositor_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, in_sof;
  logic [3:0]   in_px_valid, in_has_alpha;
  logic [127:0] in_px;
  logic [3:0]   cfg_layer_en, cfg_pipe, cfg_galpha_en;
  logic [7:0]   cfg_prio;
  logic [31:0]  cfg_galpha;
  logic [23:0]  cfg_bg;
  logic         cfg_quirk;
  logic         out_valid, out_ready;
  logic [23:0]  out_px;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  layer_compositor dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_px_valid(in_px_valid), .in_px(in_px), .in_has_alpha(in_has_alpha),
    .cfg_layer_en(cfg_layer_en), .cfg_pipe(cfg_pipe), .cfg_prio(cfg_prio),
    .cfg_galpha(cfg_galpha), .cfg_galpha_en(cfg_galpha_en), .cfg_bg(cfg_bg),
    .cfg_quirk(cfg_quirk), .out_valid(out_valid), .out_ready(out_ready), .out_px(out_px)
  );

  typedef struct packed {
    logic [127:0] px;
    logic [3:0]   pxv;
    logic [3:0]   hasa;
    logic [3:0]   en;
    logic [3:0]   pipe;
    logic [7:0]   prio;
    logic [31:0]  ga;
    logic [3:0]   gaen;
    logic         quirk;
    logic [23:0]  exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R1: layer 2 (prio 3) beats layer 0 (prio 1)
    '{{32'h0, 32'h00112233, 32'h0, 32'h00AABBCC}, 4'hF, 4'h0, 4'b0101, 4'b0000, 8'h31, 32'h0, 4'h0, 1'b0, 24'h112233},
    // R2: equal priority, layer 1 beats layer 3
    '{{32'h00778899, 32'h0, 32'h00445566, 32'h0}, 4'hF, 4'h0, 4'b1010, 4'b0000, 8'h88, 32'h0, 4'h0, 1'b0, 24'h445566},
    // R1: non-covering layer 0 is skipped despite higher priority
    '{{32'h0, 32'h0, 32'h00010203, 32'h00FFFFFF}, 4'b1110, 4'h0, 4'b0011, 4'b0000, 8'h03, 32'h0, 4'h0, 1'b0, 24'h010203},
    // R3: nothing enabled shows background
    '{{32'h0, 32'h0, 32'h0, 32'h00ABCDEF}, 4'hF, 4'h0, 4'b0000, 4'b0000, 8'h00, 32'h0, 4'h0, 1'b0, 24'h102030},
    // R5: opaque front layer replaces back
    '{{32'h0, 32'h0, 32'h00FF8040, 32'h00000000}, 4'hF, 4'h0, 4'b0011, 4'b0010, 8'h00, 32'h0, 4'h0, 1'b0, 24'hFF8040},
    // R4: front layer not covering, back passes through
    '{{32'h0, 32'h0, 32'h00FF8040, 32'h00ABCDEF}, 4'b0001, 4'h0, 4'b0011, 4'b0010, 8'h00, 32'h0, 4'h0, 1'b0, 24'hABCDEF},
    // R5: zero pixel alpha keeps back
    '{{32'h0, 32'h0, 32'h00FFFFFF, 32'h00123456}, 4'hF, 4'b0010, 4'b0011, 4'b0010, 8'h00, 32'h0, 4'h0, 1'b0, 24'h123456},
    // R5: alpha 128 of black over white
    '{{32'h0, 32'h0, 32'h80000000, 32'h00FFFFFF}, 4'hF, 4'b0010, 4'b0011, 4'b0010, 8'h00, 32'h0, 4'h0, 1'b0, 24'h7F7F7F},
    // R6: global alpha 128 on opaque white over black
    '{{32'h0, 32'h0, 32'h00FFFFFF, 32'h00000000}, 4'hF, 4'h0, 4'b0011, 4'b0010, 8'h00, 32'h00008000, 4'b0010, 1'b0, 24'h808080},
    // R6: pixel alpha 128 times global alpha 128 gives 64
    '{{32'h0, 32'h0, 32'h80FFFFFF, 32'h00000000}, 4'hF, 4'b0010, 4'b0011, 4'b0010, 8'h00, 32'h00008000, 4'b0010, 1'b0, 24'h404040},
    // R7: workaround hides alpha-format bottom layer
    '{{32'h0, 32'h0, 32'h0, 32'hFF112233}, 4'hF, 4'b0001, 4'b0001, 4'b0000, 8'h00, 32'h0, 4'h0, 1'b1, 24'h102030},
    // R7: workaround off, layer shown
    '{{32'h0, 32'h0, 32'h0, 32'hFF112233}, 4'hF, 4'b0001, 4'b0001, 4'b0000, 8'h00, 32'h0, 4'h0, 1'b0, 24'h112233},
    // R7: priority 1 is not the bottom slot
    '{{32'h0, 32'h0, 32'h0, 32'hFF112233}, 4'hF, 4'b0001, 4'b0001, 4'b0000, 8'h01, 32'h0, 4'h0, 1'b1, 24'h112233},
    // R7: global alpha below 255 also counts as carrying alpha
    '{{32'h0, 32'h0, 32'h0, 32'h00112233}, 4'hF, 4'h0, 4'b0001, 4'b0000, 8'h00, 32'h000000FE, 4'b0001, 1'b1, 24'h102030}
  };

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_vec(input vec_t v);
    in_px = v.px; in_px_valid = v.pxv; in_has_alpha = v.hasa;
    cfg_layer_en = v.en; cfg_pipe = v.pipe; cfg_prio = v.prio;
    cfg_galpha = v.ga; cfg_galpha_en = v.gaen; cfg_quirk = v.quirk;
  endtask

  task automatic send_beat(input logic sof);
    @(negedge clk);
    in_sof = sof; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic beat_and_check(input logic sof, input logic [23:0] exp, input string req);
    send_beat(sof);
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b1 && out_px === exp, req, out_px, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b1;
    in_px = '0; in_px_valid = '0; in_has_alpha = '0;
    cfg_layer_en = '0; cfg_pipe = '0; cfg_prio = '0; cfg_galpha = '0;
    cfg_galpha_en = '0; cfg_bg = 24'h102030; cfg_quirk = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R11 out_valid after reset", {23'b0, out_valid}, 24'h0);
    check(in_ready === 1'b1, "R10 in_ready idle", {23'b0, in_ready}, 24'h1);

    // R11: cleared settings apply to a beat without frame start
    cfg_layer_en = 4'b0001; in_px = {96'h0, 32'h00ABCDEF}; in_px_valid = 4'hF;
    beat_and_check(1'b0, 24'h102030, "R11 cleared settings");

    for (int i = 0; i < NV; i++) begin
      load_vec(VECS[i]);
      beat_and_check(1'b1, VECS[i].exp, $sformatf("vector %0d", i));
    end

    // R8: settings captured at frame start survive pin changes
    load_vec(VECS[0]);
    beat_and_check(1'b1, 24'h112233, "R8 frame start load");
    cfg_layer_en = 4'b0000; cfg_prio = 8'h00;
    beat_and_check(1'b0, 24'h112233, "R8 live pins ignored");
    beat_and_check(1'b1, 24'h102030, "R8 next frame start applies");

    // R9: latency of two edges
    load_vec(VECS[1]);
    send_beat(1'b1);
    check(out_valid === 1'b0, "R9 not after first edge", {23'b0, out_valid}, 24'h0);
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b1 && out_px === 24'h445566, "R9 after second edge", out_px, 24'h445566);

    // R10: back-pressure holds output and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    load_vec(VECS[4]);
    send_beat(1'b1);
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b1 && out_px === 24'hFF8040, "R10 stalled beat present", out_px, 24'hFF8040);
    check(in_ready === 1'b0, "R10 in_ready low", {23'b0, in_ready}, 24'h0);
    load_vec(VECS[6]);
    in_sof = 1'b1; in_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b1 && out_px === 24'hFF8040, "R10 output held", out_px, 24'hFF8040);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    check(out_valid === 1'b0, "R10 bubble after release", {23'b0, out_valid}, 24'h0);
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b1 && out_px === 24'h123456, "R10 waiting beat delivered once", out_px, 24'h123456);
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R10 no duplicate", {23'b0, out_valid}, 24'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule